// File: doc/BRIEF.md
# Bit-Spread PWM DAC Bank

This block produces nine pulse-width outputs from one shared time base. Eight are 6-bit channels. The other is a single 14-bit DAC channel, meant to be smoothed by an external low-pass filter into a tuning or control voltage. The shared base tick runs at half the input clock.

The 6-bit channels do not emit one contiguous pulse per period. Each data bit owns a fixed set of segments spread evenly over the period, so the ripple left after filtering sits at a higher frequency. The 14-bit channel cuts its long period into 64 short sub-periods. Its upper 8 bits set the pulse width inside every sub-period. Its lower 6 bits choose which sub-periods get one extra tick, using the same spreading rule as the 6-bit channels.

Software reaches all settings through a simple write strobe with an address and a data byte. Every output has an enable. With the enable clear, the output-enable pin is low and the data pin is held low; this stands for a high-impedance pad.

Top module: `pwm_dac_bank`

## Requirements
- R1: The base tick is one tick per two clocks. A 6-bit segment lasts 32 ticks (64 clocks), so a 6-bit period is 64 segments, or 4096 clocks.
- R2: A 6-bit channel holding value v is high for exactly v×64 clocks per period, for v from 0 to 63. The output is never high for the whole period.
- R3: Segments are numbered 0 to 63, and segment 0 is always low. For any other segment s, let k be the position of the lowest set bit of s. The segment is high when data bit 5−k is 1. This gives bit 5 the odd segments and bit 0 segment 32 alone.
- R4: Writing address c (0 to 7) stores wr_data[5:0] for 6-bit channel c. The stored value reaches the output only at the start of the next 6-bit period, so the current period completes with the old value.
- R5: The 14-bit period is 64 sub-periods of 256 ticks each (32768 clocks in total). In every sub-period the DAC output goes high at the start and stays high for H ticks or H+1 ticks, where H is the upper 8 bits.
- R6: Sub-period j gets the extra tick when the lower 6 bits select segment j under the rule of R3. Total high time per 14-bit period is therefore 2×(64×H+L) clocks, where L is the lower 6 bits.
- R7: Address 8 stages the upper 8 bits and leaves the DAC output unchanged. Address 9 carries the lower 6 bits in wr_data[5:0] and moves the staged byte together with them into the working value in one step.
- R8: Address 10 writes the 6-bit channel enables, with bit c enabling channel c. Address 11, bit 0, enables the DAC channel. A disabled output has its output-enable low and its data pin low, while the other outputs keep running.
- R9: After reset every enable is clear, every data pin is low, and all stored and working values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| pwm_o | output | 8 | 6-bit channel outputs |
| pwm_oe | output | 8 | 6-bit channel output enables |
| dac_o | output | 1 | 14-bit DAC output |
| dac_oe | output | 1 | 14-bit DAC output enable |

## Verification
The assertions check, on every cycle, that segment 0 of each 6-bit period drives all 6-bit outputs low. They also check that a 6-bit working value moves only at a period boundary, that the DAC working value moves only after a low-part write, that the enables change only on an enable write, and that no disabled output is ever high. The bench scenarios measure high time and the number of separate high runs over whole periods. These show that the duty values and the bit-spread placement are correct for both channel kinds. The scenarios also show that a write made mid-period waits for the next period, and that staging the DAC high byte alone has no effect on the output.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

  // resolution of the short channels and of the DAC fine part
  localparam int PWM_RES = 6;

  // Bit-spread rule: the lowest set bit k of idx selects data bit RES-1-k.
  // Index 0 selects nothing.
  function automatic logic spread_hit(input logic [PWM_RES-1:0] val,
                                      input logic [PWM_RES-1:0] idx);
    logic hit;
    logic found;
    hit   = 1'b0;
    found = 1'b0;
    for (int k = 0; k < PWM_RES; k++) begin
      if (!found && idx[k]) begin
        hit   = val[PWM_RES-1-k];
        found = 1'b1;
      end
    end
    return hit;
  endfunction

endpackage

// File: rtl/pwmb_timebase.sv
module pwmb_timebase
  import pwmb_pkg::*;
#(
  parameter int DIV   = 2,
  parameter int SEG_W = 5,
  parameter int SUB_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PWM_RES-1:0] seg_idx,
  output logic               wrap6,
  output logic [PWM_RES-1:0] sub_idx,
  output logic [SUB_W-1:0]   sub_pos
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CTR_W = PWM_RES + SUB_W;
  localparam int P6_W  = PWM_RES + SEG_W;

  logic [DIV_W-1:0] div_q, div_d;
  logic [CTR_W-1:0] ctr_q, ctr_d;
  logic             tick;

  always_comb begin
    tick  = (div_q == DIV_W'(DIV - 1));
    div_d = tick ? '0 : div_q + 1'b1;
    ctr_d = tick ? ctr_q + 1'b1 : ctr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ctr_q <= '0;
    end else begin
      div_q <= div_d;
      ctr_q <= ctr_d;
    end
  end

  assign seg_idx = ctr_q[P6_W-1:SEG_W];
  assign wrap6   = tick && (ctr_q[P6_W-1:0] == '1);
  assign sub_idx = ctr_q[CTR_W-1:SUB_W];
  assign sub_pos = ctr_q[SUB_W-1:0];

endmodule

// File: rtl/pwmb_ch6.sv
module pwmb_ch6
  import pwmb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [PWM_RES-1:0] wr_val,
  input  logic               wrap6,
  input  logic [PWM_RES-1:0] seg_idx,
  input  logic               en_d,
  output logic [PWM_RES-1:0] lat_o,
  output logic               pwm_o
);

  logic [PWM_RES-1:0] stage_q, stage_d;
  logic [PWM_RES-1:0] lat_q, lat_d;
  logic               out_q, out_d;

  always_comb begin
    stage_d = wr_stb ? wr_val : stage_q;
    lat_d   = wrap6 ? stage_q : lat_q;
    out_d   = en_d && spread_hit(lat_q, seg_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      lat_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      lat_q   <= lat_d;
      out_q   <= out_d;
    end
  end

  assign lat_o = lat_q;
  assign pwm_o = out_q;

endmodule

// File: rtl/pwmb_dac14.sv
module pwmb_dac14
  import pwmb_pkg::*;
#(
  parameter int SUB_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_hi,
  input  logic                       wr_lo,
  input  logic [SUB_W-1:0]           wr_val,
  input  logic [PWM_RES-1:0]         sub_idx,
  input  logic [SUB_W-1:0]           sub_pos,
  input  logic                       en_d,
  output logic [SUB_W+PWM_RES-1:0]   lat_o,
  output logic                       dac_o
);

  localparam int LAT_W = SUB_W + PWM_RES;

  logic [SUB_W-1:0] hi_q, hi_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             out_q, out_d;
  logic             extra;
  logic [SUB_W:0]   width;

  always_comb begin
    hi_d  = wr_hi ? wr_val : hi_q;
    lat_d = wr_lo ? {hi_q, wr_val[PWM_RES-1:0]} : lat_q;
    extra = spread_hit(lat_q[PWM_RES-1:0], sub_idx);
    width = {1'b0, lat_q[LAT_W-1:PWM_RES]} + {{SUB_W{1'b0}}, extra};
    out_d = en_d && ({1'b0, sub_pos} < width);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lat_q <= '0;
      out_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      lat_q <= lat_d;
      out_q <= out_d;
    end
  end

  assign lat_o = lat_q;
  assign dac_o = out_q;

endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwmb_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int DIV    = 2,
  parameter int SEG_W  = 5,
  parameter int SUB_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_CH-1:0]   pwm_o,
  output logic [N_CH-1:0]   pwm_oe,
  output logic              dac_o,
  output logic              dac_oe
);

  localparam int A_DHI  = N_CH;
  localparam int A_DLO  = N_CH + 1;
  localparam int A_EN6  = N_CH + 2;
  localparam int A_DEN  = N_CH + 3;
  localparam int LAT_W  = SUB_W + PWM_RES;

  logic [PWM_RES-1:0]            seg_idx;
  logic                          wrap6;
  logic [PWM_RES-1:0]            sub_idx;
  logic [SUB_W-1:0]              sub_pos;
  logic [N_CH-1:0][PWM_RES-1:0]  lat6;
  logic [LAT_W-1:0]              dac_lat;

  logic [N_CH-1:0] en6_q, en6_d;
  logic            den_q, den_d;
  logic            wr_dhi, wr_dlo;

  always_comb begin
    wr_dhi = wr_en && (wr_addr == ADDR_W'(A_DHI));
    wr_dlo = wr_en && (wr_addr == ADDR_W'(A_DLO));
    en6_d  = (wr_en && (wr_addr == ADDR_W'(A_EN6))) ? wr_data[N_CH-1:0] : en6_q;
    den_d  = (wr_en && (wr_addr == ADDR_W'(A_DEN))) ? wr_data[0] : den_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en6_q <= '0;
      den_q <= 1'b0;
    end else begin
      en6_q <= en6_d;
      den_q <= den_d;
    end
  end

  pwmb_timebase #(.DIV(DIV), .SEG_W(SEG_W), .SUB_W(SUB_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .seg_idx (seg_idx),
    .wrap6   (wrap6),
    .sub_idx (sub_idx),
    .sub_pos (sub_pos)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwmb_ch6 u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_en && (wr_addr == ADDR_W'(c))),
      .wr_val  (wr_data[PWM_RES-1:0]),
      .wrap6   (wrap6),
      .seg_idx (seg_idx),
      .en_d    (en6_d[c]),
      .lat_o   (lat6[c]),
      .pwm_o   (pwm_o[c])
    );
  end

  pwmb_dac14 #(.SUB_W(SUB_W)) u_dac (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_dhi),
    .wr_lo   (wr_dlo),
    .wr_val  (wr_data[SUB_W-1:0]),
    .sub_idx (sub_idx),
    .sub_pos (sub_pos),
    .en_d    (den_d),
    .lat_o   (dac_lat),
    .dac_o   (dac_o)
  );

  assign pwm_oe = en6_q;
  assign dac_oe = den_q;

endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk #(
  parameter int N_CH   = 8,
  parameter int ADDR_W = 4,
  parameter int LAT_W  = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [N_CH-1:0]       pwm_o,
  input logic [N_CH-1:0]       pwm_oe,
  input logic                  dac_o,
  input logic                  dac_oe,
  input logic [5:0]            seg_idx,
  input logic                  wrap6,
  input logic [N_CH-1:0][5:0]  lat6,
  input logic [LAT_W-1:0]      dac_lat
);

  localparam int A_DLO = N_CH + 1;
  localparam int A_EN6 = N_CH + 2;
  localparam int A_DEN = N_CH + 3;

  // segment 0 never drives any short channel high
  assert_seg0_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_idx == '0) |=> (pwm_o == '0));

  // short-channel working values move only at a period boundary
  assert_ch_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap6 |=> $stable(lat6));

  // DAC working value moves only after a low-part write
  assert_dac_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == ADDR_W'(A_DLO))) |=> $stable(dac_lat));

  // enables change only through their own addresses
  assert_oe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == ADDR_W'(A_EN6))) |=> $stable(pwm_oe));

  assert_dac_oe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == ADDR_W'(A_DEN))) |=> $stable(dac_oe));

  // a disabled output is never high
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_o & ~pwm_oe) == '0) && !(dac_o && !dac_oe));

endmodule

bind pwm_dac_bank pwm_dac_bank_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .pwm_o   (pwm_o),
  .pwm_oe  (pwm_oe),
  .dac_o   (dac_o),
  .dac_oe  (dac_oe),
  .seg_idx (seg_idx),
  .wrap6   (wrap6),
  .lat6    (lat6),
  .dac_lat (dac_lat)
);

// File: tb/pwm_dac_bank_bench.sv
`timescale 1ns/1ps
module pwm_dac_bank_bench;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] pwm_o;
  logic [7:0] pwm_oe;
  logic       dac_o;
  logic       dac_oe;

  int checks;
  int failures;
  bit done;
  int hi6 [8];
  int rs6 [8];
  int hid;
  int rsd;
  int vals [8];

  pwm_dac_bank u_pwm_dac_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_o   (pwm_o),
    .pwm_oe  (pwm_oe),
    .dac_o   (dac_o),
    .dac_oe  (dac_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model of the spreading rule (R3)
  function automatic int bhit(input int v, input int s);
    if (s == 0) return 0;
    for (int k = 0; k < 6; k++)
      if (((s >> k) & 1) != 0) return (v >> (5 - k)) & 1;
    return 0;
  endfunction

  function automatic int runs6(input int v);
    int n = 0;
    for (int s = 0; s < 64; s++)
      if (bhit(v, s) != 0 && bhit(v, (s + 63) % 64) == 0) n++;
    return n;
  endfunction

  function automatic int runs14(input int dh, input int dl);
    int n = 0;
    for (int j = 0; j < 64; j++) begin
      int len  = dh + bhit(dl, j);
      int plen = dh + bhit(dl, (j + 63) % 64);
      if (len > 0 && plen < 256) n++;
    end
    return n;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 4'(a);
    wr_data = 8'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int n);
    logic [7:0] p6;
    logic       pd;
    for (int i = 0; i < 8; i++) begin hi6[i] = 0; rs6[i] = 0; end
    hid = 0;
    rsd = 0;
    @(negedge clk);
    p6 = pwm_o;
    pd = dac_o;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        if (pwm_o[i]) hi6[i]++;
        if (pwm_o[i] && !p6[i]) rs6[i]++;
      end
      if (dac_o) hid++;
      if (dac_o && !pd) rsd++;
      p6 = pwm_o;
      pd = dac_o;
    end
  endtask

  task automatic t_reset;
    check("R9 pwm_oe after reset", int'(pwm_oe), 0);
    check("R9 pwm_o after reset", int'(pwm_o), 0);
    check("R9 dac_oe after reset", int'(dac_oe), 0);
    check("R9 dac_o after reset", int'(dac_o), 0);
  endtask

  task automatic t_disabled;
    vals = '{0, 1, 32, 63, 16, 21, 42, 8};
    for (int i = 0; i < 8; i++) wr(i, vals[i]);
    wr(8, 8'h10);
    wr(9, 8'h05);
    measure(4096);
    for (int i = 0; i < 8; i++) check("R8 disabled channel silent", hi6[i], 0);
    check("R8 disabled DAC silent", hid, 0);
    check("R8 pwm_oe still clear", int'(pwm_oe), 0);
  endtask

  task automatic t_spread;
    wr(10, 8'hFF);
    check("R8 pwm_oe set", int'(pwm_oe), 255);
    idle(4200);
    measure(4096);
    for (int i = 0; i < 8; i++) begin
      check($sformatf("R2 high clocks ch%0d", i), hi6[i], 64 * vals[i]);
      check($sformatf("R3 high runs ch%0d", i), rs6[i], runs6(vals[i]));
    end
    // single-bit value 1 gives one 64-clock segment per 4096-clock period
    check("R1 one segment per period", hi6[1], 64);
  endtask

  task automatic t_defer;
    @(negedge pwm_o[1]);
    wr(0, 32);
    measure(1900);
    check("R4 old value holds to period end", hi6[0], 0);
    idle(200);
    measure(4096);
    check("R4 new value next period", hi6[0], 64 * 32);
    check("R3 new value runs", rs6[0], 32);
    vals[0] = 32;
  endtask

  task automatic t_enable;
    wr(10, 8'hF7);
    check("R8 pwm_oe partial", int'(pwm_oe), 247);
    measure(4096);
    check("R8 disabled ch3 quiet", hi6[3], 0);
    check("R8 ch2 keeps running", hi6[2], 64 * vals[2]);
  endtask

  task automatic t_dac_case(input int dh, input int dl);
    wr(8, dh);
    wr(9, dl);
    idle(4);
    measure(32768);
    check($sformatf("R5 R6 DAC high clocks %0d/%0d", dh, dl), hid, 2 * (64 * dh + dl));
    check($sformatf("R6 DAC high runs %0d/%0d", dh, dl), rsd, runs14(dh, dl));
  endtask

  task automatic t_dac;
    wr(11, 1);
    check("R8 dac_oe set", int'(dac_oe), 1);
    wr(8, 0);
    wr(9, 0);
    measure(600);
    check("R5 zero value quiet", hid, 0);
    wr(8, 8'h80);
    measure(2048);
    check("R7 high byte alone has no effect", hid, 0);
    wr(9, 1);
    idle(4);
    measure(32768);
    check("R7 low write commits staged byte", hid, 2 * (64 * 128 + 1));
    check("R6 runs 128/1", rsd, runs14(128, 1));
    t_dac_case(0, 32);
    t_dac_case(255, 63);
    wr(11, 0);
    measure(600);
    check("R8 DAC disabled quiet", hid, 0);
    check("R8 dac_oe clear", int'(dac_oe), 0);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_disabled;
    t_spread;
    t_defer;
    t_enable;
    t_dac;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 195000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule